// File: doc/BRIEF.md
# Configurable ADC Channel Sequencer

This block picks the analog input channel that a successive-approximation converter samples next. It holds one 8-bit configuration byte, written by a single-byte strobe from an external bus front end. The upper four bits enable individual channels. The lower four bits are passed straight out as static controls for the converter and its input conditioning.

Each accepted conversion request starts a conversion on the channel the block currently points at. It reports that channel with a valid flag until the converter signals completion. The pointer then moves to the next enabled channel in ascending order, wrapping back to the lowest one.

When the external-reference control is set, the top channel is treated as the reference pin and drops out of the rotation. A fresh configuration write restarts the rotation from the lowest channel enabled by the new byte.

Top module: `adc_chan_seq`

## Requirements
- R1: After reset the configuration byte is 0xF0: `chan_idx` = 0, `chan_valid` = 0, and all four control outputs are 0.
- R2: The configuration byte maps its bits to outputs as follows: bit 3 drives `use_ext_ref`, bit 2 drives `filter_bypass` (1 = filter bypassed, 0 = filter active), bit 1 drives `bit_trial_dly` and bit 0 drives `sample_dly`. Each is held as a level from the cycle after the write.
- R3: Bit 4+i of the configuration byte enables channel i, for i = 0..3.
- R4: A `conv_req` pulse seen while idle, with at least one channel enabled, sets `chan_valid` on the next cycle, and `chan_idx` names the channel being converted.
- R5: Conversions visit the enabled channels in ascending index order and skip disabled ones. `chan_valid` is only ever high on an enabled channel.
- R6: After the highest enabled channel completes, the next conversion uses the lowest enabled channel.
- R7: With exactly one channel enabled, every conversion uses that channel.
- R8: With no channel enabled, `conv_req` is ignored and `chan_valid` stays 0.
- R9: With `use_ext_ref` = 1, channel 3 is never converted even when its enable bit is set. A byte enabling only channel 3 together with the external reference behaves as an empty mask.
- R10: A `conv_req` that arrives while a conversion is in progress is ignored. `chan_idx` and `chan_valid` stay unchanged until `conv_done`.
- R11: `conv_done` during a conversion clears `chan_valid` and advances `chan_idx` on the next cycle. `conv_done` while idle has no effect.
- R12: A configuration write ends any conversion in progress and sets `chan_idx` to the lowest channel enabled by the new byte (0 if none). In the same cycle a write takes priority over `conv_req`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | One-cycle strobe: load `cfg_data` into the configuration byte |
| cfg_data | input | 8 | Configuration byte to load |
| conv_req | input | 1 | One-cycle request to start a conversion |
| conv_done | input | 1 | One-cycle pulse: the current conversion has finished |
| chan_idx | output | 2 | Channel being converted, or the next one when idle |
| chan_valid | output | 1 | High while a conversion on `chan_idx` is in progress |
| use_ext_ref | output | 1 | External reference selected; the top channel is withheld |
| filter_bypass | output | 1 | Input filtering bypassed when 1 |
| bit_trial_dly | output | 1 | Bit-trial delay control level |
| sample_dly | output | 1 | Sample delay control level |

## Verification
The pointer and the busy flag are the whole internal state, and every corruption of them surfaces at `chan_idx` or `chan_valid` within one clock. A pointer sitting on a disabled channel shows up as a wrong index on the very next request. A lost or stuck busy flag shows up either as a `chan_valid` that fails to rise or fall one cycle after `conv_req` or `conv_done`, or as an index that moves under a repeated request. A cycle-accurate behavioural model is therefore compared on every clock. Directed sequences cover skipping, wrap-around, single-channel repetition, the empty mask, the withheld reference channel and writes that cut a conversion short.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   localparam int CTRL_BITS = 4;

   typedef struct packed {
      logic ext_ref;
      logic filt_byp;
      logic trial_dly;
      logic samp_dly;
   } seq_ctrl_t;

   // index of the lowest set bit among the first n bits, 0 when none
   function automatic int lowest_set(input logic [31:0] m, input int n);
      int r;
      r = 0;
      for (int i = n - 1; i >= 0; i--) begin
         if (m[i]) r = i;
      end
      return r;
   endfunction

endpackage

// File: rtl/adc_seq_cfg_reg.sv
module adc_seq_cfg_reg
   import adc_seq_pkg::*;
#(
   parameter int NUM_CH = 4,
   localparam int CFG_W = NUM_CH + CTRL_BITS,
   localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
   parameter logic [CFG_W-1:0] RESET_CFG = 'hF0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [CFG_W-1:0]  wdata,
   output logic [NUM_CH-1:0] mask_now,
   output logic [IDX_W-1:0]  first_new,
   output seq_ctrl_t         ctrl
);

   logic [CFG_W-1:0]  cfg_q;
   logic [NUM_CH-1:0] mask_new;
   seq_ctrl_t         ctrl_new;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  cfg_q <= RESET_CFG;
      else if (wr) cfg_q <= wdata;
   end

   assign ctrl     = seq_ctrl_t'(cfg_q[CTRL_BITS-1:0]);
   assign ctrl_new = seq_ctrl_t'(wdata[CTRL_BITS-1:0]);

   // the top channel doubles as reference pin when ext_ref is set
   for (genvar g = 0; g < NUM_CH; g++) begin : g_mask
      if (g == NUM_CH - 1) begin : g_top
         assign mask_now[g] = cfg_q[CTRL_BITS+g] & ~ctrl.ext_ref;
         assign mask_new[g] = wdata[CTRL_BITS+g] & ~ctrl_new.ext_ref;
      end else begin : g_low
         assign mask_now[g] = cfg_q[CTRL_BITS+g];
         assign mask_new[g] = wdata[CTRL_BITS+g];
      end
   end

   assign first_new = IDX_W'(lowest_set(32'(mask_new), NUM_CH));

   // R2
   ctrl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> ctrl == seq_ctrl_t'($past(wdata[CTRL_BITS-1:0])));

endmodule

// File: rtl/adc_seq_pick.sv
module adc_seq_pick #(
   parameter int NUM_CH = 4,
   localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic [NUM_CH-1:0] mask,
   input  logic [IDX_W-1:0]  cur,
   output logic [IDX_W-1:0]  nxt
);

   logic [IDX_W-1:0] lowest;
   logic [IDX_W-1:0] above;
   logic             found;

   always_comb begin
      lowest = '0;
      above  = '0;
      found  = 1'b0;
      for (int i = NUM_CH - 1; i >= 0; i--) begin
         if (mask[i]) lowest = IDX_W'(i);
         if (mask[i] && (i > int'(cur))) begin
            above = IDX_W'(i);
            found = 1'b1;
         end
      end
      nxt = found ? above : lowest;
   end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
   parameter int NUM_CH = 4,
   localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
   parameter logic [IDX_W-1:0] RESET_PTR = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [IDX_W-1:0]  first_new,
   input  logic [NUM_CH-1:0] mask,
   input  logic [IDX_W-1:0]  nxt,
   input  logic              conv_req,
   input  logic              conv_done,
   output logic [IDX_W-1:0]  ptr,
   output logic              busy
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         ptr  <= RESET_PTR;
      end else if (cfg_wr) begin
         busy <= 1'b0;
         ptr  <= first_new;
      end else if (busy) begin
         if (conv_done) begin
            busy <= 1'b0;
            ptr  <= nxt;
         end
      end else if (conv_req && (mask != '0)) begin
         busy <= 1'b1;
      end
   end

   // R5
   valid_on_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> mask[ptr]);
   // R8
   empty_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mask == '0) |-> !busy);
   // R10
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !conv_done && !cfg_wr) |=> (busy && $stable(ptr)));
   // R11
   done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && conv_done && !cfg_wr) |=> !busy);
   // R11
   idle_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && conv_done && !conv_req && !cfg_wr) |=> (!busy && $stable(ptr)));
   // R12
   wr_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr |=> !busy);

endmodule

// File: rtl/adc_chan_seq.sv
module adc_chan_seq
   import adc_seq_pkg::*;
#(
   parameter int NUM_CH = 4,
   localparam int CFG_W = NUM_CH + CTRL_BITS,
   localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
   parameter logic [CFG_W-1:0] RESET_CFG = 'hF0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr,
   input  logic [CFG_W-1:0] cfg_data,
   input  logic             conv_req,
   input  logic             conv_done,
   output logic [IDX_W-1:0] chan_idx,
   output logic             chan_valid,
   output logic             use_ext_ref,
   output logic             filter_bypass,
   output logic             bit_trial_dly,
   output logic             sample_dly
);

   localparam logic [IDX_W-1:0] RESET_PTR =
      IDX_W'(lowest_set(32'(RESET_CFG[CFG_W-1:CTRL_BITS]), NUM_CH));

   if (NUM_CH < 2 || NUM_CH > 16) begin : g_bad_ch
      $error("adc_chan_seq: NUM_CH must lie in 2..16");
   end

   logic [NUM_CH-1:0] mask_now;
   logic [IDX_W-1:0]  first_new;
   logic [IDX_W-1:0]  nxt;
   seq_ctrl_t         ctrl;

   adc_seq_cfg_reg #(.NUM_CH(NUM_CH), .RESET_CFG(RESET_CFG)) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (cfg_wr),
      .wdata     (cfg_data),
      .mask_now  (mask_now),
      .first_new (first_new),
      .ctrl      (ctrl)
   );

   adc_seq_pick #(.NUM_CH(NUM_CH)) u_pick (
      .mask (mask_now),
      .cur  (chan_idx),
      .nxt  (nxt)
   );

   adc_seq_ctrl #(.NUM_CH(NUM_CH), .RESET_PTR(RESET_PTR)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_wr    (cfg_wr),
      .first_new (first_new),
      .mask      (mask_now),
      .nxt       (nxt),
      .conv_req  (conv_req),
      .conv_done (conv_done),
      .ptr       (chan_idx),
      .busy      (chan_valid)
   );

   assign use_ext_ref   = ctrl.ext_ref;
   assign filter_bypass = ctrl.filt_byp;
   assign bit_trial_dly = ctrl.trial_dly;
   assign sample_dly    = ctrl.samp_dly;

endmodule

// File: tb/adc_chan_seq_tb.sv
module adc_chan_seq_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_wr = 1'b0;
   logic [7:0] cfg_data = 8'h00;
   logic       conv_req = 1'b0;
   logic       conv_done = 1'b0;
   logic [1:0] chan_idx;
   logic       chan_valid, use_ext_ref, filter_bypass, bit_trial_dly, sample_dly;

   int checks = 0;
   int failures = 0;
   int cycles = 0;
   string phase = "R1";

   // behavioural reference state
   int m_cfg = 'hF0;
   int m_busy = 0;
   int m_ptr = 0;

   always #4 clk = ~clk;   // 125 MHz

   adc_chan_seq u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
      .conv_req(conv_req), .conv_done(conv_done), .chan_idx(chan_idx),
      .chan_valid(chan_valid), .use_ext_ref(use_ext_ref),
      .filter_bypass(filter_bypass), .bit_trial_dly(bit_trial_dly),
      .sample_dly(sample_dly)
   );

   function automatic int eff_mask(int c);
      int m;
      m = (c >> 4) & 'hF;
      if (c & 8) m = m & 7;
      return m;
   endfunction

   function automatic int lowest_of(int m);
      for (int c = 0; c < 4; c++) if ((m >> c) & 1) return c;
      return 0;
   endfunction

   function automatic int following(int m, int p);
      for (int k = 1; k <= 4; k++) begin
         int c;
         c = (p + k) % 4;
         if ((m >> c) & 1) return c;
      end
      return p;
   endfunction

   always @(posedge clk) begin
      cycles++;
      if (!rst_n) begin
         m_cfg = 'hF0; m_busy = 0; m_ptr = 0;
      end else if (cfg_wr) begin
         m_cfg = int'(cfg_data); m_busy = 0; m_ptr = lowest_of(eff_mask(m_cfg));
      end else if (m_busy != 0) begin
         if (conv_done) begin
            m_busy = 0; m_ptr = following(eff_mask(m_cfg), m_ptr);
         end
      end else if (conv_req && eff_mask(m_cfg) != 0) begin
         m_busy = 1;
      end
   end

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
      end
   endtask

   // compare against the model on every clock, away from the edge
   always @(negedge clk) begin
      if (rst_n) begin
         chk({phase, " model idx"}, int'(chan_idx), m_ptr);
         chk({phase, " model valid"}, int'(chan_valid), m_busy);
         chk({phase, " model ctrl"},
             int'({use_ext_ref, filter_bypass, bit_trial_dly, sample_dly}), m_cfg & 'hF);
      end
   end

   always @(posedge clk) begin
      if (cycles > 20000) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic step(logic w, logic [7:0] d, logic r, logic dn);
      cfg_wr = w; cfg_data = d; conv_req = r; conv_done = dn;
      @(negedge clk);
      cfg_wr = 1'b0; conv_req = 1'b0; conv_done = 1'b0;
   endtask

   task automatic expect_ch(string tag, int idx, int vld);
      chk({tag, " idx"}, int'(chan_idx), idx);
      chk({tag, " valid"}, int'(chan_valid), vld);
   endtask

   // one full conversion: request, then done
   task automatic convert(string tag, int idx);
      step(1'b0, 8'h00, 1'b1, 1'b0);
      expect_ch(tag, idx, 1);
      step(1'b0, 8'h00, 1'b0, 1'b1);
      chk({tag, " done clears"}, int'(chan_valid), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      phase = "R1";
      expect_ch("R1 reset", 0, 0);
      chk("R1 reset ctrl", int'({use_ext_ref, filter_bypass, bit_trial_dly, sample_dly}), 0);

      phase = "R4";
      convert("R4 first", 0);
      phase = "R5";
      convert("R5 asc", 1);
      convert("R5 asc", 2);
      convert("R5 asc", 3);
      phase = "R6";
      convert("R6 wrap", 0);

      phase = "R3";
      step(1'b1, 8'h50, 1'b0, 1'b0);   // channels 0 and 2
      convert("R3 ch0", 0);
      phase = "R5";
      convert("R5 skip", 2);
      phase = "R6";
      convert("R6 wrap2", 0);

      phase = "R7";
      step(1'b1, 8'h20, 1'b0, 1'b0);   // channel 1 only
      convert("R7 single", 1);
      convert("R7 single", 1);

      phase = "R2";
      step(1'b1, 8'h05, 1'b0, 1'b0);
      chk("R2 filter_bypass", int'(filter_bypass), 1);
      chk("R2 sample_dly", int'(sample_dly), 1);
      chk("R2 bit_trial_dly", int'(bit_trial_dly), 0);
      phase = "R8";
      step(1'b0, 8'h00, 1'b1, 1'b0);
      expect_ch("R8 empty", 0, 0);

      phase = "R9";
      step(1'b1, 8'h88, 1'b0, 1'b0);   // only ch3 + ext ref
      chk("R9 ext_ref", int'(use_ext_ref), 1);
      step(1'b0, 8'h00, 1'b1, 1'b0);
      chk("R9 ch3 withheld", int'(chan_valid), 0);
      step(1'b1, 8'hFA, 1'b0, 1'b0);
      chk("R2 bit_trial_dly", int'(bit_trial_dly), 1);
      convert("R9 seq", 0);
      convert("R9 seq", 1);
      convert("R9 seq", 2);
      convert("R9 no ch3", 0);

      phase = "R10";
      step(1'b1, 8'hF0, 1'b0, 1'b0);
      step(1'b0, 8'h00, 1'b1, 1'b0);
      step(1'b0, 8'h00, 1'b1, 1'b0);
      expect_ch("R10 req while busy", 0, 1);
      repeat (3) @(negedge clk);
      expect_ch("R10 held", 0, 1);
      step(1'b0, 8'h00, 1'b0, 1'b1);
      expect_ch("R11 advance", 1, 0);

      phase = "R11";
      step(1'b0, 8'h00, 1'b0, 1'b1);
      expect_ch("R11 idle done", 1, 0);

      phase = "R12";
      step(1'b0, 8'h00, 1'b1, 1'b0);
      expect_ch("R12 busy", 1, 1);
      step(1'b1, 8'hC0, 1'b0, 1'b0);   // channels 2,3
      expect_ch("R12 abort", 2, 0);
      step(1'b1, 8'h30, 1'b1, 1'b0);   // write wins over req
      expect_ch("R12 priority", 0, 0);
      convert("R12 restart", 0);
      convert("R12 next", 1);

      repeat (2) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule